// File: doc/BRIEF.md
# Flash Chip-Erase Command Sequencer

This block models the command side of a byte-wide flash device around its whole-array erase. Write cycles arrive as single-cycle strobes, each with an address and a data byte. A six-write unlock-and-confirm sequence starts an internal erase. The erase first drives every location to 00h, then clears every location to FFh, and each phase lasts a parameterized number of clock cycles. While the erase runs, and after it ends, reads return a status byte rather than array contents. The status byte carries a completion flag, two toggling bits and a sticky failure flag.

There is no real array. A single byte register stands for the uniform contents of the whole array. It starts at a parameter value, becomes 00h when pre-programming ends and becomes FFh when the erase succeeds. A test input lets the erase end in failure. A host reads that status with a single-cycle read strobe. The read data is combinational from internal state during the strobe cycle.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `ready` is 1 and a read returns the parameter `INIT_FILL` (default A5h).
- R2: Six writes start the erase, and `ready` is 0 in the cycle after the sixth write. The writes are AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h. Only address bits 14..0 are compared.
- R3: A wrong address or data on any of those six writes drops the sequence back to array reads. No erase starts, `ready` stays 1 and reads return the array byte.
- R4: Without suspension, `ready` stays 0 for exactly `PROG_CYCLES + ERASE_CYCLES` clock cycles.
- R5: During the erase, reads return bit 7 = 0 and bit 5 = 0, and all other bits are 0 except bits 6 and 2. Bits 6 and 2 read 0 on the first read after the start and invert on each further read.
- R6: After a successful erase, reads return 80h until the next write. A later F0h write returns to array reads, which give FFh.
- R7: While the erase runs, every write whose data is neither F0h nor B0h is ignored and does not change its duration.
- R8: A B0h write during the erase suspends it. While suspended, `ready` is 1 and reads return 80h without toggling. A 30h write resumes the erase, which then finishes the cycles it had left. The cycle that takes the B0h write does not count.
- R9: An F0h write during the erase or during suspension aborts to array reads. If the abort comes after pre-programming has ended, the array reads 00h.
- R10: If `force_fail` is 1 in the last erase cycle, the erase fails. `ready` returns to 1 and reads give 20h. Every write except F0h is ignored, and F0h returns to array reads, which give 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_en | input | 1 | Read strobe, one cycle per read |
| force_fail | input | 1 | Test input: makes the erase end in failure |
| rd_data | output | 8 | Array byte or status byte |
| ready | output | 1 | 1 when idle, 0 while the erase is running |

## Verification
The unlock sequence is tried in four forms: correct, with a wrong address on the second write, with a wrong set-up byte on the third write, and with a wrong confirm byte on the sixth write. The sixth-write failure is the case that separates a decoder checking every cycle from one that only checks the opening pair. Erases run in four ways: undisturbed, with an ignored foreign write and a suspend/resume, with a reset partway through, and with a forced failure. Exact busy-cycle counts separate a correct phase timer from an off-by-one. Comparing the busy count with suspension against the count without it shows that a suspend freezes progress. The status reads before, during and after suspension separate toggle-on-read from toggle-on-clock.

// File: rtl/fes_pkg.sv
package fes_pkg;
   typedef enum logic [2:0] {
      ENG_ARRAY, ENG_PREPROG, ENG_ERASE, ENG_DONE, ENG_SUSP, ENG_FAIL
   } eng_t;

   typedef enum logic [2:0] {
      SEQ_IDLE, SEQ_U1, SEQ_U2, SEQ_SETUP, SEQ_U4, SEQ_U5
   } seq_t;

   localparam logic [14:0] ADR_FIRST  = 15'h5555;
   localparam logic [14:0] ADR_SECOND = 15'h2AAA;
   localparam logic [7:0]  KEY_FIRST  = 8'hAA;
   localparam logic [7:0]  KEY_SECOND = 8'h55;
   localparam logic [7:0]  CMD_SETUP  = 8'h80;
   localparam logic [7:0]  CMD_CHIP   = 8'h10;
   localparam logic [7:0]  CMD_RESET  = 8'hF0;
   localparam logic [7:0]  CMD_SUSP   = 8'hB0;
   localparam logic [7:0]  CMD_RESUME = 8'h30;
endpackage

// File: rtl/fes_cmd_decode.sv
module fes_cmd_decode
   import fes_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output logic              start
);
   seq_t st, st_n;
   logic hit_first, hit_second, at_first;

   assign at_first   = (wr_addr[14:0] == ADR_FIRST);
   assign hit_first  = at_first && (wr_data == KEY_FIRST);
   assign hit_second = (wr_addr[14:0] == ADR_SECOND) && (wr_data == KEY_SECOND);

   always_comb begin
      st_n  = st;
      start = 1'b0;
      if (en && wr_en) begin
         case (st)
            SEQ_IDLE:  st_n = hit_first  ? SEQ_U1 : SEQ_IDLE;
            SEQ_U1:    st_n = hit_second ? SEQ_U2 : SEQ_IDLE;
            SEQ_U2:    st_n = (at_first && wr_data == CMD_SETUP) ? SEQ_SETUP : SEQ_IDLE;
            SEQ_SETUP: st_n = hit_first  ? SEQ_U4 : SEQ_IDLE;
            SEQ_U4:    st_n = hit_second ? SEQ_U5 : SEQ_IDLE;
            SEQ_U5: begin
               st_n  = SEQ_IDLE;
               start = at_first && (wr_data == CMD_CHIP);
            end
            default:   st_n = SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= SEQ_IDLE;
      else        st <= st_n;
   end

   // R3
   seq_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != $past(st)) |-> $past(en && wr_en));
endmodule

// File: rtl/fes_erase_engine.sv
module fes_erase_engine
   import fes_pkg::*;
#(
   parameter int          PROG_CYCLES  = 64,
   parameter int          ERASE_CYCLES = 256,
   parameter logic [7:0]  INIT_FILL    = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       force_fail,
   output eng_t       state,
   output logic [7:0] array_byte,
   output logic       ready
);
   localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(LONGEST + 1);
   localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);

   logic [CNT_W-1:0] cnt;
   logic             susp_in_erase;
   logic             busy, cmd_reset, cmd_susp;

   assign busy      = (state == ENG_PREPROG) || (state == ENG_ERASE);
   assign ready     = !busy;
   assign cmd_reset = wr_en && (wr_data == CMD_RESET);
   assign cmd_susp  = wr_en && (wr_data == CMD_SUSP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= ENG_ARRAY;
         cnt           <= '0;
         array_byte    <= INIT_FILL;
         susp_in_erase <= 1'b0;
      end else begin
         case (state)
            ENG_ARRAY: if (start) begin
               state <= ENG_PREPROG;
               cnt   <= '0;
            end
            ENG_DONE: begin
               if (start) begin
                  state <= ENG_PREPROG;
                  cnt   <= '0;
               end else if (wr_en) begin
                  state <= ENG_ARRAY;
               end
            end
            ENG_PREPROG: begin
               if (cmd_reset) state <= ENG_ARRAY;
               else if (cmd_susp) begin
                  state         <= ENG_SUSP;
                  susp_in_erase <= 1'b0;
               end else if (cnt == PROG_LAST) begin
                  state      <= ENG_ERASE;
                  cnt        <= '0;
                  array_byte <= 8'h00;
               end else cnt <= cnt + 1'b1;
            end
            ENG_ERASE: begin
               if (cmd_reset) state <= ENG_ARRAY;
               else if (cmd_susp) begin
                  state         <= ENG_SUSP;
                  susp_in_erase <= 1'b1;
               end else if (cnt == ERASE_LAST) begin
                  if (force_fail) state <= ENG_FAIL;
                  else begin
                     state      <= ENG_DONE;
                     array_byte <= 8'hFF;
                  end
               end else cnt <= cnt + 1'b1;
            end
            ENG_SUSP: begin
               if (cmd_reset) state <= ENG_ARRAY;
               else if (wr_en && wr_data == CMD_RESUME)
                  state <= susp_in_erase ? ENG_ERASE : ENG_PREPROG;
            end
            ENG_FAIL: if (cmd_reset) state <= ENG_ARRAY;
            default: state <= ENG_ARRAY;
         endcase
      end
   end

   // R10
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_FAIL && !cmd_reset) |=> (state == ENG_FAIL));

   // R9
   busy_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_reset) |=> (state == ENG_ARRAY && ready));

   // R4
   phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_ERASE) |-> (cnt <= ERASE_LAST));
endmodule

// File: rtl/fes_status_mux.sv
module fes_status_mux
   import fes_pkg::*;
#(
   parameter bit DQ2_TOGGLE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  eng_t       state,
   input  logic [7:0] array_byte,
   input  logic       rd_en,
   input  logic       start,
   output logic [7:0] rd_data
);
   logic tog, dq2, busy;

   assign busy = (state == ENG_PREPROG) || (state == ENG_ERASE);

   generate
      if (DQ2_TOGGLE) begin : g_dq2_tog
         assign dq2 = tog;
      end else begin : g_dq2_flat
         assign dq2 = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)            tog <= 1'b0;
      else if (start)        tog <= 1'b0;
      else if (rd_en && busy) tog <= ~tog;
   end

   always_comb begin
      case (state)
         ENG_PREPROG, ENG_ERASE: rd_data = {1'b0, tog, 3'b000, dq2, 2'b00};
         ENG_DONE, ENG_SUSP:     rd_data = 8'h80;
         ENG_FAIL:               rd_data = 8'h20;
         default:                rd_data = array_byte;
      endcase
   end

   // R5
   toggle_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_en) |=> (!busy || rd_data[6] != $past(rd_data[6])));

   // R10
   fail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ENG_FAIL) |-> (rd_data[5] && !rd_data[7]));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import fes_pkg::*;
#(
   parameter int         ADDR_W       = 16,
   parameter int         PROG_CYCLES  = 64,
   parameter int         ERASE_CYCLES = 256,
   parameter logic [7:0] INIT_FILL    = 8'hA5,
   parameter bit         DQ2_TOGGLE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              rd_en,
   input  logic              force_fail,
   output logic [7:0]        rd_data,
   output logic              ready
);
   generate
      if (ADDR_W < 15) begin : g_bad_addr
         $error("ADDR_W must cover address bit 14");
      end
      if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_bad_len
         $error("phase lengths must be at least one cycle");
      end
   endgenerate

   eng_t       state;
   logic [7:0] array_byte;
   logic       start, dec_en;

   assign dec_en = (state == ENG_ARRAY) || (state == ENG_DONE);

   fes_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .en(dec_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .start(start)
   );

   fes_erase_engine #(
      .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .INIT_FILL(INIT_FILL)
   ) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en), .wr_data(wr_data),
      .force_fail(force_fail), .state(state), .array_byte(array_byte), .ready(ready)
   );

   fes_status_mux #(.DQ2_TOGGLE(DQ2_TOGGLE)) u_stat (
      .clk(clk), .rst_n(rst_n), .state(state), .array_byte(array_byte),
      .rd_en(rd_en), .start(start), .rd_data(rd_data)
   );

   // R2
   start_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !ready);
endmodule

// File: tb/flash_erase_seq_test.sv
module flash_erase_seq_test;
   localparam int P = 8;
   localparam int E = 24;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic        force_fail = 1'b0;
   logic [7:0]  rd_data;
   logic        ready;

   int checks = 0;
   int fails  = 0;
   int busy_cnt = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   flash_erase_seq #(.ADDR_W(16), .PROG_CYCLES(P), .ERASE_CYCLES(E), .INIT_FILL(8'hA5)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .force_fail(force_fail), .rd_data(rd_data), .ready(ready)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_expect(input logic [7:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic unlock(input logic [7:0] confirm);
      wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h80);
      wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, confirm);
   endtask

   task automatic wait_ready();
      while (!ready) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      #2;
      if (rd_en) begin
         if (exp_q.size() == 0) check(1'b0, "unexpected read", rd_data, 0);
         else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(rd_data == e, t, rd_data, e);
         end
      end
   end

   always @(negedge clk) if (rst_n && !ready) busy_cnt++;

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ready == 1'b1, "R1 ready after reset", ready, 1);
      rd_expect(8'hA5, "R1 initial array byte");

      // R3 aborts
      wr(16'h5555, 8'hAA); wr(16'h1234, 8'h55);
      rd_expect(8'hA5, "R3 wrong second address");
      wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0);
      rd_expect(8'hA5, "R3 wrong set-up byte");
      unlock(8'h30);
      check(ready == 1'b1, "R3 wrong confirm keeps ready", ready, 1);
      rd_expect(8'hA5, "R3 wrong confirm reads array");

      // R2 R4 R5 R6 normal erase
      busy_cnt = 0;
      unlock(8'h10);
      check(ready == 1'b0, "R2 ready low after sixth write", ready, 0);
      rd_expect(8'h00, "R5 first busy read");
      rd_expect(8'h44, "R5 second busy read");
      rd_expect(8'h00, "R5 third busy read");
      wait_ready();
      check(busy_cnt == P + E, "R4 busy duration", busy_cnt, P + E);
      rd_expect(8'h80, "R6 done status");
      rd_expect(8'h80, "R6 done status repeat");
      wr(16'h0000, 8'hF0);
      rd_expect(8'hFF, "R6 erased array");

      // R7 R8 ignored write, suspend, resume
      busy_cnt = 0;
      unlock(8'h10);
      wr(16'h5555, 8'hAA);
      rd_expect(8'h00, "R7 status after ignored write");
      wr(16'h0000, 8'hB0);
      check(ready == 1'b1, "R8 ready high while suspended", ready, 1);
      rd_expect(8'h80, "R8 suspended status");
      rd_expect(8'h80, "R8 suspended status no toggle");
      repeat (20) @(negedge clk);
      wr(16'h0000, 8'h30);
      check(ready == 1'b0, "R8 busy after resume", ready, 0);
      rd_expect(8'h44, "R8 toggle resumes");
      wait_ready();
      check(busy_cnt == P + E + 1, "R8 R7 busy duration with suspend", busy_cnt, P + E + 1);
      rd_expect(8'h80, "R8 done after resume");
      wr(16'h0000, 8'hF0);

      // R9 reset during erase phase
      unlock(8'h10);
      repeat (P + 3) @(negedge clk);
      check(ready == 1'b0, "R9 still busy before reset", ready, 0);
      wr(16'h0000, 8'hF0);
      check(ready == 1'b1, "R9 ready after reset command", ready, 1);
      rd_expect(8'h00, "R9 array pre-programmed");

      // R10 forced failure
      force_fail = 1'b1;
      unlock(8'h10);
      wait_ready();
      force_fail = 1'b0;
      rd_expect(8'h20, "R10 failure status");
      wr(16'h5555, 8'hAA);
      rd_expect(8'h20, "R10 failure sticky after other write");
      check(ready == 1'b1, "R10 ready in failure", ready, 1);
      wr(16'h0000, 8'hF0);
      rd_expect(8'h00, "R10 array after reset from failure");

      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule